// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address. It reads two page-table entries from main memory to do so, with no translation cache in between. A requester offers one translation at a time. Each request carries the virtual address, a flag that marks a user-mode access and a flag that marks a write. The walker reads a first-level entry and then, when that entry is valid, a second-level entry. It returns the physical address, the page's cacheable and bufferable attributes and a fault code. The result stays on the outputs until the requester acknowledges it.

Every table address is built by joining bit fields, so the address path has no adder. The first-level table is 16 KiB and must sit on a 16 KiB boundary. Its base comes from a register input, which the walker samples at the moment it accepts a request. Each second-level table holds 256 word entries, and its base is a 22-bit field of the first-level entry. Memory is reached through a read port that has a valid/ready request and a response strobe, and the response may arrive after any number of cycles.

Top module: `pgwalk`

## Requirements
- R1: Out of reset, req_ready is 1, mem_req_valid is 0 and res_valid is 0.
- R2: The first read goes to {root_base[31:14], vaddr[31:20], 2'b00}, using the root_base value present in the cycle the request was accepted. A later change to root_base has no effect on that walk.
- R3: When bit 0 of the first-level entry is 0, the result carries fault code 1 (translation), res_paddr 0 and both attributes 0, and no second read is issued.
- R4: When bit 0 of the first-level entry is 1, the second read goes to {l1_entry[31:10], vaddr[19:12], 2'b00}.
- R5: When bit 0 of the second-level entry is 0, the result carries fault code 1, res_paddr 0 and both attributes 0.
- R6: A permitted access returns fault code 0, res_paddr = {l2_entry[31:12], vaddr[11:0]}, res_cacheable = l2_entry[3] and res_bufferable = l2_entry[4].
- R7: A user access (req_user = 1) to a page whose entry bit 1 is 0 returns fault code 2 (permission), res_paddr 0 and both attributes 0. The same page is reachable with req_user = 0.
- R8: A write (req_write = 1) to a page whose entry bit 2 is 0 returns fault code 2. A read of the same page succeeds.
- R9: While mem_req_ready is 0, mem_req_valid stays 1 and mem_req_addr stays unchanged. Any number of cycles may separate a read request from its response.
- R10: res_valid and the result fields stay steady until res_ack. While a walk or a result is pending, req_ready is 0. One cycle after res_ack the walker is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| root_base | input | 32 | Byte address of the first-level table, 16 KiB aligned |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_user | input | 1 | 1 = user-mode access |
| req_write | input | 1 | 1 = write access |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 32 | Byte address of the table entry to read |
| mem_rsp_valid | input | 1 | Read data valid for one cycle |
| mem_rsp_data | input | 32 | Table entry read from memory |
| res_valid | output | 1 | Result available |
| res_ack | input | 1 | Requester has taken the result |
| res_paddr | output | 32 | Physical address, 0 on a fault |
| res_fault | output | 2 | 0 none, 1 translation, 2 permission |
| res_cacheable | output | 1 | Page may be cached |
| res_bufferable | output | 1 | Writes to the page may be buffered |

## Verification
The hardest cases to reach from the ports are a read request held by memory for several cycles, a slow response, and a change of root_base while a walk is already in flight. The bench memory model takes a programmable grant delay and a programmable response delay, and it records every address it grants. One walk stalls both of these while the bench rewrites root_base just after acceptance. The recorded addresses then show whether the sampled base and the held request were kept. The same walk leaves its result unacknowledged for several cycles to test that the result holds steady.

// File: rtl/pgwalk_pkg.sv
// Shared types for the page table walker: fault codes, walk states and
// the bit positions of the flags in a table entry.
package pgwalk_pkg;
    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_XLATE = 2'd1,
        FLT_PERM  = 2'd2
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_DONE
    } walk_st_e;

    localparam int ENT_VALID = 0;
    localparam int ENT_USER  = 1;
    localparam int ENT_WRITE = 2;
    localparam int ENT_CACHE = 3;
    localparam int ENT_BUF   = 4;
endpackage

// File: rtl/pgwalk_addr.sv
// Table entry address former. It picks the first- or second-level entry
// address and builds it only by joining fields, with no arithmetic.
// Assumes IDX1_W + IDX2_W + OFF_W == VA_W and word-sized entries.
module pgwalk_addr #(
    parameter int VA_W   = 32,
    parameter int IDX1_W = 12,
    parameter int IDX2_W = 8,
    parameter int OFF_W  = 12
) (
    input  logic [VA_W-1:0] root_q,
    input  logic [VA_W-1:0] vaddr_q,
    input  logic [VA_W-1:0] l1_entry_q,
    input  logic            sel_l2,
    output logic [VA_W-1:0] tbl_addr
);
    localparam int ROOT_HI_W = VA_W - IDX1_W - 2;
    localparam int L2B_W     = VA_W - IDX2_W - 2;

    logic [VA_W-1:0] l1_addr;
    logic [VA_W-1:0] l2_addr;
    logic            unused_addr_bits;

    // Join the aligned table base with the index and a zero byte offset.
    always_comb begin
        l1_addr  = {root_q[VA_W-1 -: ROOT_HI_W], vaddr_q[VA_W-1 -: IDX1_W], 2'b00};
        l2_addr  = {l1_entry_q[VA_W-1 -: L2B_W], vaddr_q[OFF_W +: IDX2_W], 2'b00};
        tbl_addr = sel_l2 ? l2_addr : l1_addr;
    end

    assign unused_addr_bits = ^{root_q[VA_W-ROOT_HI_W-1:0], l1_entry_q[VA_W-L2B_W-1:0],
                                vaddr_q[OFF_W-1:0]};
endmodule

// File: rtl/pgwalk_perm.sv
// Second-level entry evaluation. It checks validity and access rights and
// forms the physical address and attributes. All outputs are zero on a fault.
// Assumes the entry layout given by the package bit positions.
module pgwalk_perm #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12
) (
    input  logic [VA_W-1:0]      l2_entry,
    input  logic [OFF_W-1:0]     offset,
    input  logic                 is_user,
    input  logic                 is_write,
    output pgwalk_pkg::fault_e   fault,
    output logic [VA_W-1:0]      paddr,
    output logic                 cacheable,
    output logic                 bufferable
);
    import pgwalk_pkg::*;

    logic unused_entry_bits;

    // Pick the fault class, then gate the address and attributes on success.
    always_comb begin
        if (!l2_entry[ENT_VALID])
            fault = FLT_XLATE;
        else if ((is_user && !l2_entry[ENT_USER]) || (is_write && !l2_entry[ENT_WRITE]))
            fault = FLT_PERM;
        else
            fault = FLT_NONE;
        paddr      = (fault == FLT_NONE) ? {l2_entry[VA_W-1:OFF_W], offset} : '0;
        cacheable  = (fault == FLT_NONE) && l2_entry[ENT_CACHE];
        bufferable = (fault == FLT_NONE) && l2_entry[ENT_BUF];
    end

    assign unused_entry_bits = ^l2_entry[OFF_W-1:ENT_BUF+1];
endmodule

// File: rtl/pgwalk_ctrl.sv
// Walk sequencer. It steps through request, first read, second read and
// result hold, and raises one-cycle load strobes for the datapath.
// Assumes memory responses arrive only after an accepted read request.
module pgwalk_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic mem_req_ready,
    input  logic mem_rsp_valid,
    input  logic l1_ok,
    input  logic res_ack,
    output logic req_ready,
    output logic mem_req_valid,
    output logic sel_l2,
    output logic cap_req,
    output logic fin_l1_fault,
    output logic cap_l1,
    output logic fin_l2,
    output logic res_valid
);
    import pgwalk_pkg::*;

    walk_st_e st, st_nx;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Next-state choice.
    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE:    if (req_valid)     st_nx = ST_L1_REQ;
            ST_L1_REQ:  if (mem_req_ready) st_nx = ST_L1_WAIT;
            ST_L1_WAIT: if (mem_rsp_valid) st_nx = l1_ok ? ST_L2_REQ : ST_DONE;
            ST_L2_REQ:  if (mem_req_ready) st_nx = ST_L2_WAIT;
            ST_L2_WAIT: if (mem_rsp_valid) st_nx = ST_DONE;
            ST_DONE:    if (res_ack)       st_nx = ST_IDLE;
            default:                       st_nx = ST_IDLE;
        endcase
    end

    // Handshake outputs and datapath strobes.
    always_comb begin
        req_ready     = (st == ST_IDLE);
        mem_req_valid = (st == ST_L1_REQ) || (st == ST_L2_REQ);
        sel_l2        = (st == ST_L2_REQ) || (st == ST_L2_WAIT);
        cap_req       = (st == ST_IDLE) && req_valid;
        cap_l1        = (st == ST_L1_WAIT) && mem_rsp_valid && l1_ok;
        fin_l1_fault  = (st == ST_L1_WAIT) && mem_rsp_valid && !l1_ok;
        fin_l2        = (st == ST_L2_WAIT) && mem_rsp_valid;
        res_valid     = (st == ST_DONE);
    end
endmodule

// File: rtl/pgwalk.sv
// Two-level page table walker top. It captures a request and the table
// base, walks both table levels through the memory read port and holds the
// result until it is acknowledged. Assumes a 16 KiB aligned root_base.
module pgwalk #(
    parameter int VA_W   = 32,
    parameter int IDX1_W = 12,
    parameter int IDX2_W = 8,
    parameter int OFF_W  = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [VA_W-1:0] root_base,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic            req_user,
    input  logic            req_write,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [VA_W-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [VA_W-1:0] mem_rsp_data,
    output logic            res_valid,
    input  logic            res_ack,
    output logic [VA_W-1:0] res_paddr,
    output logic [1:0]      res_fault,
    output logic            res_cacheable,
    output logic            res_bufferable
);
    import pgwalk_pkg::*;

    logic [VA_W-1:0] root_q, vaddr_q, l1_entry_q;
    logic            user_q, write_q;
    logic            sel_l2, cap_req, cap_l1, fin_l1_fault, fin_l2;
    fault_e          l2_fault;
    logic [VA_W-1:0] l2_paddr;
    logic            l2_cache, l2_buf;

    pgwalk_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .l1_ok(mem_rsp_data[ENT_VALID]), .res_ack(res_ack),
        .req_ready(req_ready), .mem_req_valid(mem_req_valid), .sel_l2(sel_l2),
        .cap_req(cap_req), .fin_l1_fault(fin_l1_fault), .cap_l1(cap_l1),
        .fin_l2(fin_l2), .res_valid(res_valid)
    );

    pgwalk_addr #(.VA_W(VA_W), .IDX1_W(IDX1_W), .IDX2_W(IDX2_W), .OFF_W(OFF_W)) u_addr (
        .root_q(root_q), .vaddr_q(vaddr_q), .l1_entry_q(l1_entry_q),
        .sel_l2(sel_l2), .tbl_addr(mem_req_addr)
    );

    pgwalk_perm #(.VA_W(VA_W), .OFF_W(OFF_W)) u_perm (
        .l2_entry(mem_rsp_data), .offset(vaddr_q[OFF_W-1:0]),
        .is_user(user_q), .is_write(write_q), .fault(l2_fault),
        .paddr(l2_paddr), .cacheable(l2_cache), .bufferable(l2_buf)
    );

    // Capture the request and the table base when the walk starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            root_q  <= '0;
            vaddr_q <= '0;
            user_q  <= 1'b0;
            write_q <= 1'b0;
        end else if (cap_req) begin
            root_q  <= root_base;
            vaddr_q <= req_vaddr;
            user_q  <= req_user;
            write_q <= req_write;
        end
    end

    // Keep the first-level entry for the second read address.
    always_ff @(posedge clk) begin
        if (!rst_n)      l1_entry_q <= '0;
        else if (cap_l1) l1_entry_q <= mem_rsp_data;
    end

    // Load the result at the end of the walk and hold it until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_paddr      <= '0;
            res_fault      <= FLT_NONE;
            res_cacheable  <= 1'b0;
            res_bufferable <= 1'b0;
        end else if (fin_l1_fault) begin
            res_paddr      <= '0;
            res_fault      <= FLT_XLATE;
            res_cacheable  <= 1'b0;
            res_bufferable <= 1'b0;
        end else if (fin_l2) begin
            res_paddr      <= l2_paddr;
            res_fault      <= l2_fault;
            res_cacheable  <= l2_cache;
            res_bufferable <= l2_buf;
        end
    end
endmodule

// File: rtl/pgwalk_sva.sv
// Protocol and address checker for the page table walker, bound to the top.
// It keeps its own copy of the accepted request and counts the table reads
// granted since then.
module pgwalk_sva #(
    parameter int VA_W   = 32,
    parameter int IDX1_W = 12,
    parameter int OFF_W  = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic [VA_W-1:0] root_base,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_vaddr,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [VA_W-1:0] mem_req_addr,
    input logic            res_valid,
    input logic            res_ack,
    input logic [VA_W-1:0] res_paddr,
    input logic [1:0]      res_fault
);
    localparam int ROOT_HI_W = VA_W - IDX1_W - 2;

    logic [VA_W-1:0] ck_va, ck_root;
    logic [1:0]      ck_n;

    // Shadow copy of the accepted request and count of granted reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_va <= '0; ck_root <= '0; ck_n <= '0;
        end else if (req_valid && req_ready) begin
            ck_va <= req_vaddr; ck_root <= root_base; ck_n <= '0;
        end else if (mem_req_valid && mem_req_ready && ck_n != 2'd3) begin
            ck_n <= ck_n + 2'd1;
        end
    end

    a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    a_r10_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ack |=> res_valid && $stable(res_paddr) && $stable(res_fault));

    a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || res_valid) |-> !req_ready);

    a_r2_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && ck_n == 2'd0 |->
        mem_req_addr == {ck_root[VA_W-1 -: ROOT_HI_W], ck_va[VA_W-1 -: IDX1_W], 2'b00});

    a_r3_two_reads_max: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> ck_n < 2'd2);

    a_r6_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_fault == 2'd0 |-> res_paddr[OFF_W-1:0] == ck_va[OFF_W-1:0]);
endmodule

bind pgwalk pgwalk_sva #(.VA_W(VA_W), .IDX1_W(IDX1_W), .OFF_W(OFF_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .root_base(root_base), .req_valid(req_valid),
    .req_ready(req_ready), .req_vaddr(req_vaddr), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .res_valid(res_valid), .res_ack(res_ack), .res_paddr(res_paddr),
    .res_fault(res_fault)
);

// File: tb/pgwalk_bench.sv
// Directed bench for the page table walker with a latency-programmable
// memory responder that records every granted address.
module pgwalk_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] root_base = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_user = 1'b0, req_write = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        res_valid;
    logic        res_ack = 1'b0;
    logic [31:0] res_paddr;
    logic [1:0]  res_fault;
    logic        res_cacheable, res_bufferable;

    int checks = 0, errors = 0;

    // Responder state.
    logic [31:0] resp_q [2];
    logic [31:0] seen_addr [2];
    logic [31:0] cap_a, pend_d;
    int  nseen = 0, ready_lat = 0, rsp_lat = 0, wcnt = 0, rcnt = 0;
    bit  pend = 0;

    // Results of the last walk.
    logic [31:0] r_paddr;
    logic [1:0]  r_fault;
    logic        r_c, r_b;
    bit          r_stable;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgwalk u_pgwalk (
        .clk(clk), .rst_n(rst_n), .root_base(root_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_user(req_user), .req_write(req_write),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_ack(res_ack),
        .res_paddr(res_paddr), .res_fault(res_fault),
        .res_cacheable(res_cacheable), .res_bufferable(res_bufferable)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Memory model: grants after ready_lat cycles, answers after rsp_lat more.
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pend) begin
                if (rcnt == 0) begin
                    mem_rsp_valid = 1'b1; mem_rsp_data = pend_d; pend = 0;
                end else rcnt--;
            end
            if (mem_req_ready) begin
                mem_req_ready = 1'b0;
                if (nseen < 2) begin
                    seen_addr[nseen] = cap_a; pend_d = resp_q[nseen];
                end else pend_d = '0;
                nseen++; pend = 1; rcnt = rsp_lat; wcnt = ready_lat;
            end else if (mem_req_valid && !pend && !mem_rsp_valid) begin
                if (wcnt == 0) begin
                    mem_req_ready = 1'b1; cap_a = mem_req_addr;
                end else wcnt--;
            end
        end
    end

    // One full translation; optionally rewrites root_base after acceptance.
    task automatic walk(input logic [31:0] va, input bit user, input bit wr,
                        input logic [31:0] root, input logic [31:0] l1e,
                        input logic [31:0] l2e, input int hold, input bit poke_root);
        resp_q[0] = l1e; resp_q[1] = l2e; nseen = 0;
        seen_addr[0] = 'x; seen_addr[1] = 'x;
        wcnt = ready_lat;
        root_base = root; req_vaddr = va; req_user = user; req_write = wr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke_root) root_base = ~root & 32'hFFFF_C000;
        for (int i = 0; i < 300 && !res_valid; i++) @(negedge clk);
        check("R10 result arrives", {31'd0, res_valid}, 32'd1);
        r_paddr = res_paddr; r_fault = res_fault; r_c = res_cacheable; r_b = res_bufferable;
        r_stable = 1;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (!res_valid || res_paddr !== r_paddr || res_fault !== r_fault || req_ready)
                r_stable = 0;
        end
        res_ack = 1'b1;
        @(negedge clk);
        res_ack = 1'b0;
        check("R10 idle after ack", {30'd0, res_valid, req_ready}, 32'd1);
    endtask

    function automatic logic [31:0] l1_of(input logic [31:0] root, input logic [31:0] va);
        return {root[31:14], va[31:20], 2'b00};
    endfunction

    function automatic logic [31:0] l2_of(input logic [31:0] l1e, input logic [31:0] va);
        return {l1e[31:10], va[19:12], 2'b00};
    endfunction

    task automatic t_reset;
        check("R1 req_ready", {31'd0, req_ready}, 32'd1);
        check("R1 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
        check("R1 res_valid", {31'd0, res_valid}, 32'd0);
    endtask

    task automatic t_success;
        logic [31:0] va = 32'h1234_5678, root = 32'h0004_C000;
        logic [31:0] l1e = 32'h2AB0_F401, l2e = 32'hABCD_E01F;
        walk(va, 1'b1, 1'b1, root, l1e, l2e, 0, 0);
        check("R2 first address", seen_addr[0], l1_of(root, va));
        check("R4 second address", seen_addr[1], l2_of(l1e, va));
        check("R6 paddr", r_paddr, 32'hABCD_E678);
        check("R6 fault none", {30'd0, r_fault}, 32'd0);
        check("R6 attributes", {30'd0, r_c, r_b}, 32'd3);
        walk(32'hFFF0_0ABC, 1'b0, 1'b0, 32'hFFFF_C000, 32'h0000_0401, 32'h0000_1009, 0, 0);
        check("R2 first address top", seen_addr[0], 32'hFFFF_FFFC);
        check("R4 second address low", seen_addr[1], 32'h0000_0400);
        check("R6 paddr cache only", r_paddr, 32'h0000_1ABC);
        check("R6 attributes cache only", {30'd0, r_c, r_b}, 32'd2);
    endtask

    task automatic t_l1_fault;
        walk(32'h8000_1000, 1'b0, 1'b0, 32'h0010_0000, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 0, 0);
        repeat (3) @(negedge clk);
        check("R3 single read", nseen, 32'd1);
        check("R3 fault code", {30'd0, r_fault}, 32'd1);
        check("R3 paddr zero", r_paddr, 32'd0);
        check("R3 attributes zero", {30'd0, r_c, r_b}, 32'd0);
    endtask

    task automatic t_l2_fault;
        walk(32'h0040_3123, 1'b0, 1'b0, 32'h0000_4000, 32'h0001_0001, 32'hFFFF_F01E, 0, 0);
        check("R5 fault code", {30'd0, r_fault}, 32'd1);
        check("R5 paddr zero", r_paddr, 32'd0);
        check("R5 attributes zero", {30'd0, r_c, r_b}, 32'd0);
    endtask

    task automatic t_user_perm;
        walk(32'h0000_5ABC, 1'b1, 1'b0, 32'h0000_8000, 32'h0000_0C01, 32'h7777_701D, 0, 0);
        check("R7 user denied", {30'd0, r_fault}, 32'd2);
        check("R7 paddr zero", r_paddr, 32'd0);
        walk(32'h0000_5ABC, 1'b0, 1'b0, 32'h0000_8000, 32'h0000_0C01, 32'h7777_701D, 0, 0);
        check("R7 supervisor allowed", {30'd0, r_fault}, 32'd0);
        check("R7 supervisor paddr", r_paddr, 32'h7777_7ABC);
    endtask

    task automatic t_write_perm;
        walk(32'h0300_0010, 1'b0, 1'b1, 32'h0002_0000, 32'h0000_2001, 32'h0123_4003, 0, 0);
        check("R8 write denied", {30'd0, r_fault}, 32'd2);
        walk(32'h0300_0010, 1'b0, 1'b0, 32'h0002_0000, 32'h0000_2001, 32'h0123_4003, 0, 0);
        check("R8 read allowed", {30'd0, r_fault}, 32'd0);
        check("R8 read paddr", r_paddr, 32'h0123_4010);
    endtask

    task automatic t_slow_memory;
        logic [31:0] va = 32'hC0DE_2468, root = 32'h0123_C000;
        logic [31:0] l1e = 32'h5555_5401, l2e = 32'h9876_5007;
        ready_lat = 4; rsp_lat = 5;
        walk(va, 1'b1, 1'b1, root, l1e, l2e, 6, 1);
        check("R2 base sampled at accept", seen_addr[0], l1_of(root, va));
        check("R9 second address held", seen_addr[1], l2_of(l1e, va));
        check("R9 paddr under latency", r_paddr, 32'h9876_5468);
        check("R10 result held until ack", {31'd0, r_stable}, 32'd1);
        ready_lat = 0; rsp_lat = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_success();
        t_l1_fault();
        t_l2_fault();
        t_user_perm();
        t_write_perm();
        t_slow_memory();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule